// File: doc/BRIEF.md
# Serial EEPROM Page Write Target

This block is the two-wire bus target side of a small serial EEPROM. A register array stands in for the nonvolatile cells. Both bus lines are sampled on the system clock. The block finds START and STOP conditions, shifts bytes in and out, and answers each byte with an acknowledge. A write transfer carries a select byte, then a byte address, then one or more data bytes. The data bytes collect in an eight-entry page buffer. When the master closes the transfer with STOP, a timed program cycle moves the buffered bytes into the array.

While the program cycle runs, the block takes no part in bus traffic. A master can therefore repeat START plus a write select until one is acknowledged, and that first acknowledge means the cycle has finished. Reads use the random form: a write select, a byte address, a repeated START, a read select, and then one byte shifted out most significant bit first. The data line is open-drain. `sda_oe` high means the block pulls the line low.

Top module: `eep_page_target`

## Requirements
- R1: A select byte is acknowledged only when bits 7:4 equal TYPE_CODE (default 4'b1010) and bit 1 equals CHIP_BIT (default 0). Bit 0 is the direction, with 1 meaning read, and bits 3:2 are don't-care. Any other select is not acknowledged, and every byte after it is also not acknowledged until the next START.
- R2: In a write transfer, the block acknowledges the byte-address byte and each data byte by pulling SDA low during the ninth clock.
- R3: After each data byte, only the low three address bits advance. The upper five bits stay fixed, so a ninth data byte wraps to the first location of the same eight-byte page and replaces the byte written there, and no location outside the page changes.
- R4: A STOP that follows at least one complete data byte raises `busy` for exactly PROG_CYCLES system clocks. When `busy` falls, the array holds the buffered bytes.
- R5: While `busy` is high, no select is acknowledged and `sda_oe` stays low.
- R6: A STOP that arrives before any data byte, or a START in the middle of a write, drops the buffered bytes. No program cycle starts and the array is left unchanged.
- R7: A read select that follows a byte-address write and a repeated START is acknowledged. The byte at that address is then returned MSB first, and SDA is released during the master's acknowledge slot.
- R8: After reset, `busy` and `sda_oe` are low and every array location reads 8'hFF.
- R9: The block changes `sda_oe` only while the synchronised SCL is low, so it never creates a START or STOP itself.
- R10: `sda_oe` is high only during an acknowledge slot or while a read data bit of zero is being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired value) |
| sda_oe | output | 1 | High pulls the data line low |
| busy | output | 1 | High while the program cycle runs |

## Verification
The checks that run on every cycle cover the following:
- the data line stays released while the program cycle runs;
- the drive changes only while the clock line is low;
- the drive is raised only in an acknowledge slot or a read bit;
- the page buffer is empty whenever the block is idle and not programming;
- a program cycle never starts while another one is running;
- the page base address stays still during a program cycle.

Only the bench scenarios can show the other behaviours. These are the exact program cycle length, the wrap of the page address and the bytes it replaces, the absence of any write after an early STOP or a repeated START, the NACK followed by an ACK during polling, and the values of the read bits.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int ADDR_W     = 8;
    localparam int PAGE_BYTES = 8;
    localparam int LANE_W     = $clog2(PAGE_BYTES);
    localparam int BASE_W     = ADDR_W - LANE_W;
    localparam int MEM_DEPTH  = 1 << ADDR_W;
    localparam logic [7:0] ERASED = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEL, ST_ADDR, ST_DATA, ST_RDSTART, ST_READ, ST_IGNORE
    } eep_state_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LANE_W-1:0] lane;
    } eep_addr_t;

    function automatic logic sel_hit(input logic [7:0] b, input logic [3:0] kind,
                                     input logic chip);
        return (b[7:4] == kind) && (b[1] == chip);
    endfunction
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    assign scl_s    = scl_ff[1];
    assign sda_s    = sda_ff[1];
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic commit
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (go)        cnt <= CW'(CYCLES);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy   = (cnt != '0);
    assign commit = (cnt == CW'(1));

    // R4
    go_idle_chk: assert property (@(posedge clk) disable iff (rst) go |-> !busy);
    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> cnt == CW'(CYCLES));
endmodule

// File: rtl/eep_page_store.sv
module eep_page_store import eep_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [7:0]        wr_data,
    input  logic              drop,
    input  logic              commit,
    input  logic [BASE_W-1:0] base,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              any_valid
);
    logic [PAGE_BYTES-1:0]      lane_v;
    logic [PAGE_BYTES-1:0][7:0] lane_d;
    logic [7:0]                 mem [MEM_DEPTH];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        logic       v;
        logic [7:0] d;
        always_ff @(posedge clk) begin
            if (rst || drop || commit)                  v <= 1'b0;
            else if (wr_en && wr_lane == LANE_W'(g))    v <= 1'b1;
        end
        always_ff @(posedge clk) begin
            if (wr_en && wr_lane == LANE_W'(g)) d <= wr_data;
        end
        assign lane_v[g] = v;
        assign lane_d[g] = d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= ERASED;
        end else if (commit) begin
            for (int l = 0; l < PAGE_BYTES; l++)
                if (lane_v[l]) mem[{base, LANE_W'(l)}] <= lane_d[l];
        end
    end

    assign rd_data   = mem[rd_addr];
    assign any_valid = |lane_v;

    // R5
    write_commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !wr_en);
endmodule

// File: rtl/eep_page_target.sv
module eep_page_target import eep_pkg::*; #(
    parameter logic [3:0] TYPE_CODE   = 4'b1010,
    parameter logic       CHIP_BIT    = 1'b0,
    parameter int         PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic busy
);
    logic scl_s, sda_s, start_ev, stop_ev, scl_rise, scl_fall;
    logic commit, any_valid, go, wr_en, drop, counting;
    logic [7:0] rd_data, rx_byte, shreg, txreg;
    logic [3:0] bitcnt;
    logic       ack_q, oe_q;
    eep_addr_t  addr_q;
    eep_state_e state;

    eep_line_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
        .scl_rise(scl_rise), .scl_fall(scl_fall));

    eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(go), .busy(busy), .commit(commit));

    eep_page_store u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lane(addr_q.lane),
        .wr_data(rx_byte), .drop(drop), .commit(commit), .base(addr_q.base),
        .rd_addr(addr_q), .rd_data(rd_data), .any_valid(any_valid));

    assign rx_byte  = {shreg[6:0], sda_s};
    assign counting = state inside {ST_SEL, ST_ADDR, ST_DATA, ST_RDSTART, ST_READ};
    assign go       = stop_ev && state == ST_DATA && any_valid;
    assign drop     = !busy && (start_ev || (stop_ev && !go));
    assign wr_en    = !busy && !start_ev && !stop_ev && scl_rise && counting &&
                      bitcnt == 4'd7 && state == ST_DATA;
    assign sda_oe   = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            txreg  <= '0;
            ack_q  <= 1'b0;
            oe_q   <= 1'b0;
            addr_q <= '0;
        end else if (busy) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (start_ev) begin
            state  <= ST_SEL;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (stop_ev) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (counting) begin
            if (scl_rise) begin
                shreg  <= rx_byte;
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == 4'd7) begin
                    unique case (state)
                        ST_SEL: begin
                            ack_q <= sel_hit(rx_byte, TYPE_CODE, CHIP_BIT);
                            if (!sel_hit(rx_byte, TYPE_CODE, CHIP_BIT)) state <= ST_IGNORE;
                            else if (rx_byte[0])                        state <= ST_RDSTART;
                            else                                        state <= ST_ADDR;
                        end
                        ST_ADDR: begin
                            addr_q <= eep_addr_t'(rx_byte);
                            ack_q  <= 1'b1;
                            state  <= ST_DATA;
                        end
                        ST_DATA: begin
                            addr_q.lane <= addr_q.lane + 1'b1;
                            ack_q       <= 1'b1;
                        end
                        default: ack_q <= 1'b0;
                    endcase
                end
            end else if (scl_fall) begin
                if (bitcnt == 4'd8) begin
                    oe_q <= ack_q;
                end else if (bitcnt == 4'd9) begin
                    bitcnt <= '0;
                    if (state == ST_RDSTART) begin
                        state <= ST_READ;
                        txreg <= rd_data;
                        oe_q  <= ~rd_data[7];
                    end else begin
                        if (state == ST_READ) state <= ST_IGNORE;
                        oe_q <= 1'b0;
                    end
                end else if (state == ST_READ && bitcnt != 4'd0) begin
                    oe_q <= ~txreg[3'd7 - bitcnt[2:0]];
                end
            end
        end
    end

    // R5
    busy_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);
    // R9
    oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> !$past(scl_s));
    // R10
    oe_slot_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (bitcnt >= 4'd8 || state == ST_READ));
    // R6
    page_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !busy) |-> !any_valid);
    // R3
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q.base));
endmodule

// File: tb/eep_page_target_tb.sv
module eep_page_target_tb_top;
    localparam int PROG = 300;
    localparam int QT   = 5;
    // addr | count | first data | probe addr | expected at probe
    localparam logic [35:0] VEC [5] = '{
        36'h10_1_3C_10_3C,
        36'h23_3_50_25_52,
        36'h40_8_A0_47_A7,
        36'h3E_4_70_38_72,
        36'h58_9_10_58_18
    };

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1;
    logic sda_oe, busy, sda_bus;
    int checks = 0, failures = 0, busy_run = 0, busy_len = 0, busy_pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    eep_page_target #(.PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .busy(busy));

    always @(negedge clk) begin
        if (busy) busy_run++;
        else if (busy_run != 0) begin
            busy_len = busy_run; busy_run = 0; busy_pulses++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q(); repeat (QT) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; q(); scl = 1; q(); sda_m = 0; q(); scl = 0; q(); endtask
    task automatic bus_stop();  sda_m = 0; q(); scl = 1; q(); sda_m = 1; q(); endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl = 1; q(); q(); scl = 0; q();
        end
        sda_m = 1; q(); scl = 1; q(); ack = (sda_bus == 1'b0); q(); scl = 0; q();
    endtask

    task automatic recv_byte(output logic [7:0] b, output bit drv);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1; q(); scl = 1; q(); b[i] = sda_bus; q(); scl = 0; q();
        end
        sda_m = 1; q(); scl = 1; q(); drv = sda_oe; q(); scl = 0; q();
    endtask

    task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
        bit ack, drv;
        bus_start(); send_byte(8'hA0, ack); send_byte(a, ack);
        bus_start(); send_byte(8'hA1, ack);
        chk(ack, "R7 read select ack", ack, 1);
        recv_byte(d, drv);
        chk(!drv, "R7 sda released in master ack slot", drv, 0);
        bus_stop();
    endtask

    task automatic page_write(input logic [7:0] a, input int n, input logic [7:0] base);
        bit ack;
        int p0;
        p0 = busy_pulses;
        bus_start(); send_byte(8'hA0, ack);
        chk(ack, "R1 write select ack", ack, 1);
        send_byte(a, ack);
        chk(ack, "R2 address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(base + 8'(k), ack);
            chk(ack, "R2 data ack", ack, 1);
        end
        bus_stop();
        repeat (PROG + 40) @(negedge clk);
        chk(busy_pulses == p0 + 1, "R4 one program cycle", busy_pulses - p0, 1);
        chk(busy_len == PROG, "R4 busy length", busy_len, PROG);
    endtask

    initial begin
        logic [7:0] d;
        bit ack;
        int p0, polls;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy, "R8 busy low after reset", busy, 0);
        chk(!sda_oe, "R8 sda_oe low after reset", sda_oe, 0);
        rand_read(8'h00, d);
        chk(d == 8'hFF, "R8 erased array", d, 8'hFF);

        for (int v = 0; v < 5; v++) begin
            page_write(VEC[v][35:28], int'(VEC[v][27:24]), VEC[v][23:16]);
            rand_read(VEC[v][15:8], d);
            chk(d == VEC[v][7:0], "R3 R4 R7 vector readback", d, VEC[v][7:0]);
        end

        // R3: page confinement after the wrapping writes
        rand_read(8'h40, d);
        chk(d == 8'hA0, "R3 next page untouched", d, 8'hA0);
        rand_read(8'h59, d);
        chk(d == 8'h11, "R3 wrap replaced first byte only", d, 8'h11);

        // R1: foreign select codes
        bus_start(); send_byte(8'hB0, ack);
        chk(!ack, "R1 wrong type code nack", ack, 0);
        send_byte(8'h10, ack);
        chk(!ack, "R1 bytes after bad select ignored", ack, 0);
        bus_stop();
        bus_start(); send_byte(8'hA2, ack);
        chk(!ack, "R1 wrong chip bit nack", ack, 0);
        bus_stop();

        // R6: STOP after address only, and START in mid write
        p0 = busy_pulses;
        bus_start(); send_byte(8'hA0, ack); send_byte(8'h10, ack); bus_stop();
        bus_start(); send_byte(8'hA0, ack); send_byte(8'h10, ack); send_byte(8'h99, ack);
        bus_start(); bus_stop();
        repeat (PROG + 40) @(negedge clk);
        chk(busy_pulses == p0, "R6 no program cycle", busy_pulses - p0, 0);
        rand_read(8'h10, d);
        chk(d == 8'h3C, "R6 array unchanged", d, 8'h3C);

        // R5: polling during the program cycle
        bus_start(); send_byte(8'hA0, ack); send_byte(8'h60, ack); send_byte(8'h5A, ack);
        bus_stop();
        bus_start(); send_byte(8'hA0, ack); bus_stop();
        chk(!ack, "R5 select nacked while busy", ack, 0);
        polls = 0;
        do begin
            bus_start(); send_byte(8'hA0, ack); bus_stop();
            polls++;
        end while (!ack && polls < 20);
        chk(ack && !busy, "R5 poll acked after cycle", ack, 1);
        chk(busy_len == PROG, "R4 busy length while polled", busy_len, PROG);
        rand_read(8'h60, d);
        chk(d == 8'h5A, "R4 committed byte", d, 8'h5A);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule